// File: doc/BRIEF.md
# Masked Pseudo-Random Noise Offset Generator

This block produces a dithered 12-bit sample for a converter's output register. On each accepted trigger it takes a 12-bit base value and adds the low bits of a 12-bit linear feedback shift register. A 4-bit selector chooses how many of those bits take part. The sum is clamped at full scale, sent down a short register pipeline, and shown on `dout` with a one-cycle `dout_vld` strobe. The shift register then takes one step, so the next trigger sees a fresh pseudo-random value.

The register starts from a fixed seed and returns to that seed while the wave mode field is in its disabled state. A NOR term injects a one if the register ever holds all zeros. The selector is captured only while the channel is disabled, so the noise amplitude cannot change in the middle of a run. Register decoding, trigger source selection and the analog stage sit outside this block.

Top module: `noise_offset_gen`

## Requirements
- R1: After a synchronous reset, `dout` is 0, `dout_vld` is 0, the selector register is 0 and the shift register holds 0x0AA. The first accepted trigger with selector 15 and base 0 therefore yields 0x0AA.
- R2: A trigger is accepted only when `trig`, `trig_en` and noise mode (`wave_mode` = 2'b01) are all true at a rising edge. Any other trigger is ignored: no `dout_vld`, `dout` holds, and the shift register does not step.
- R3: For a trigger accepted at edge k, the result appears on `dout` at edge k+2, with `dout_vld` high for that one cycle. The result uses the base and shift register values present at edge k. `dout` changes at no other time.
- R4: Each accepted trigger steps the register as next = {fb, cur[11:1]}. Here fb = cur[0]^cur[1]^cur[4]^cur[6] (polynomial x^12+x^6+x^4+x+1), and fb is forced to 1 when cur is all zeros.
- R5: A captured selector value n from 0 to 10 passes register bits n down to 0 and clears the rest. Any value of 11 or more passes all 12 bits.
- R6: The sum of the base and the masked register value never wraps. Any total above 0xFFF is output as 0xFFF.
- R7: At every rising edge where `wave_mode` is 2'b00, the shift register reloads to 0x0AA, whatever the trigger inputs are.
- R8: `mask_sel` is captured at every rising edge where `chan_en` is 0. While `chan_en` is 1 it is ignored, and triggers keep using the last captured value.
- R9: Triggers accepted on consecutive cycles each produce their own result, in order, on consecutive cycles, with the register stepping once per trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; the selector is captured while low |
| trig_en | input | 1 | Trigger enable |
| wave_mode | input | 2 | Wave mode: 00 off (reload seed), 01 noise, others inactive here |
| mask_sel | input | 4 | Noise amplitude selector |
| trig | input | 1 | Trigger strobe |
| base | input | 12 | Base sample value |
| dout | output | 12 | Dithered sample for the output register |
| dout_vld | output | 1 | One-cycle strobe when `dout` is loaded |

## Verification
A directed first trigger after reset, with base 0 and all mask bits open, exposes the seed directly. Sweeping the selector from 0 to 15 over a reloaded seed separates each mask width, including the clamp at 11 and above. Near-full-scale bases tell a saturating sum apart from one that wraps. Triggers with trigger enable low, or with a wave mode other than noise, show that rejected triggers neither emit a result nor step the sequence. A later accepted trigger would reveal a skipped step. Selector changes while the channel is enabled, back-to-back triggers, and long constrained-random runs with occasional mode reloads check ordering, pipeline timing and the feedback sequence against a model in the bench.

// File: rtl/noise_gen_pkg.sv
package noise_gen_pkg;
  localparam int DATA_W_DEF = 12;
  localparam int SEL_W_DEF  = 4;

  typedef enum logic [1:0] {
    WAVE_OFF   = 2'b00,
    WAVE_NOISE = 2'b01,
    WAVE_TRI_A = 2'b10,
    WAVE_TRI_B = 2'b11
  } wave_e;
endpackage

// File: rtl/nz_lfsr.sv
module nz_lfsr #(
  parameter int           W       = 12,
  parameter logic [W-1:0] TAPS    = 12'h053,
  parameter logic [W-1:0] PRELOAD = 12'h0AA
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reload,
  input  logic         step,
  output logic [W-1:0] state_q
);
  logic fb;

  // parity of tapped bits, with zero-state escape
  assign fb = (^(state_q & TAPS)) | ~(|state_q);

  always_ff @(posedge clk) begin
    if (rst || reload)
      state_q <= PRELOAD;
    else if (step)
      state_q <= {fb, state_q[W-1:1]};
  end
endmodule

// File: rtl/nz_mask.sv
module nz_mask #(
  parameter int W     = 12,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [SEL_W-1:0] sel,
  output logic [SEL_W-1:0] sel_q,
  output logic [W-1:0]     mask
);
  always_ff @(posedge clk) begin
    if (rst)
      sel_q <= '0;
    else if (capture)
      sel_q <= sel;
  end

  // bit i is open when the selector reaches i
  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [SEL_W-1:0] IDX = SEL_W'(i);
    assign mask[i] = (sel_q >= IDX);
  end
endmodule

// File: rtl/nz_sum_pipe.sv
module nz_sum_pipe #(
  parameter int W   = 12,
  parameter int LAT = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] base,
  input  logic [W-1:0] offs,
  output logic [W-1:0] dout,
  output logic         dout_vld
);
  localparam int NSTG = LAT - 1;

  logic [W:0]   sum_w;
  logic [W-1:0] sat_w;
  logic [W-1:0] pd [NSTG];
  logic [NSTG-1:0] pv;

  assign sum_w = {1'b0, base} + {1'b0, offs};
  assign sat_w = sum_w[W] ? {W{1'b1}} : sum_w[W-1:0];

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          pv[0] <= 1'b0;
          pd[0] <= '0;
        end else begin
          pv[0] <= in_vld;
          pd[0] <= sat_w;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) begin
          pv[s] <= 1'b0;
          pd[s] <= '0;
        end else begin
          pv[s] <= pv[s-1];
          pd[s] <= pd[s-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= pv[NSTG-1];
      if (pv[NSTG-1])
        dout <= pd[NSTG-1];
    end
  end
endmodule

// File: rtl/noise_offset_gen.sv
module noise_offset_gen
  import noise_gen_pkg::*;
#(
  parameter int           W       = DATA_W_DEF,
  parameter int           SEL_W   = SEL_W_DEF,
  parameter int           LAT     = 3,
  parameter logic [W-1:0] TAPS    = 12'h053,
  parameter logic [W-1:0] PRELOAD = 12'h0AA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_en,
  input  logic             trig_en,
  input  logic [1:0]       wave_mode,
  input  logic [SEL_W-1:0] mask_sel,
  input  logic             trig,
  input  logic [W-1:0]     base,
  output logic [W-1:0]     dout,
  output logic             dout_vld
);
  logic             accept;
  logic             reload;
  logic [W-1:0]     lfsr_q;
  logic [W-1:0]     mask;
  logic [SEL_W-1:0] sel_q;

  assign reload = (wave_e'(wave_mode) == WAVE_OFF);
  assign accept = trig & trig_en & (wave_e'(wave_mode) == WAVE_NOISE);

  nz_lfsr #(.W(W), .TAPS(TAPS), .PRELOAD(PRELOAD)) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .reload  (reload),
    .step    (accept),
    .state_q (lfsr_q)
  );

  nz_mask #(.W(W), .SEL_W(SEL_W)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .capture (~chan_en),
    .sel     (mask_sel),
    .sel_q   (sel_q),
    .mask    (mask)
  );

  nz_sum_pipe #(.W(W), .LAT(LAT)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (accept),
    .base     (base),
    .offs     (lfsr_q & mask),
    .dout     (dout),
    .dout_vld (dout_vld)
  );
endmodule

// File: rtl/noise_offset_gen_chk.sv
module noise_offset_gen_chk #(
  parameter int           W       = 12,
  parameter int           SEL_W   = 4,
  parameter logic [W-1:0] PRELOAD = 12'h0AA
) (
  input logic             clk,
  input logic             rst,
  input logic             chan_en,
  input logic             trig_en,
  input logic [1:0]       wave_mode,
  input logic             trig,
  input logic [W-1:0]     dout,
  input logic             dout_vld,
  input logic [W-1:0]     lfsr,
  input logic [SEL_W-1:0] sel_q
);
  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0);

  // R7
  seed_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (wave_mode == 2'b00) |=> (lfsr == PRELOAD));

  // R2
  idle_no_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!(trig && trig_en && wave_mode == 2'b01) && wave_mode != 2'b00)
      |=> $stable(lfsr));

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !dout_vld |-> $stable(dout));

  // R8
  sel_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(chan_en)) |-> $stable(sel_q));
endmodule

bind noise_offset_gen noise_offset_gen_chk #(
  .W(W), .SEL_W(SEL_W), .PRELOAD(PRELOAD)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .chan_en   (chan_en),
  .trig_en   (trig_en),
  .wave_mode (wave_mode),
  .trig      (trig),
  .dout      (dout),
  .dout_vld  (dout_vld),
  .lfsr      (lfsr_q),
  .sel_q     (sel_q)
);

// File: tb/noise_offset_gen_bench.sv
`timescale 1ns/1ps
module noise_offset_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        chan_en = 1'b0;
  logic        trig_en = 1'b0;
  logic [1:0]  wave_mode = 2'b00;
  logic [3:0]  mask_sel = 4'd0;
  logic        trig = 1'b0;
  logic [11:0] base = 12'd0;
  logic [11:0] dout;
  logic        dout_vld;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  noise_offset_gen u_noise_offset_gen (
    .clk(clk), .rst(rst), .chan_en(chan_en), .trig_en(trig_en),
    .wave_mode(wave_mode), .mask_sel(mask_sel), .trig(trig),
    .base(base), .dout(dout), .dout_vld(dout_vld)
  );

  // reference functions from the requirements
  function automatic logic [11:0] f_step(input logic [11:0] c);
    logic fb;
    fb = c[0] ^ c[1] ^ c[4] ^ c[6];
    if (c == 12'd0) fb = 1'b1;
    return {fb, c[11:1]};
  endfunction

  function automatic logic [11:0] f_mask(input logic [3:0] n);
    if (n >= 4'd11) return 12'hFFF;
    return 12'((13'd1 << (n + 1)) - 13'd1);
  endfunction

  function automatic logic [11:0] f_sat(input logic [11:0] b, input logic [11:0] o);
    logic [12:0] s;
    s = {1'b0, b} + {1'b0, o};
    return s[12] ? 12'hFFF : s[11:0];
  endfunction

  // model state
  logic [11:0] m_lfsr, m_d0, m_d1, m_out;
  logic [3:0]  m_sel;
  logic        m_v0, m_v1, m_vld;
  logic        m_acc;

  assign m_acc = trig && trig_en && (wave_mode == 2'b01);

  always @(posedge clk) begin
    if (rst) begin
      m_lfsr <= 12'h0AA; m_sel <= 4'd0;
      m_d0 <= 0; m_d1 <= 0; m_v0 <= 0; m_v1 <= 0;
      m_out <= 0; m_vld <= 0;
    end else begin
      m_v0 <= m_acc;
      m_d0 <= f_sat(base, m_lfsr & f_mask(m_sel));
      m_v1 <= m_v0;
      m_d1 <= m_d0;
      m_vld <= m_v1;
      if (m_v1) m_out <= m_d1;
      if (wave_mode == 2'b00) m_lfsr <= 12'h0AA;
      else if (m_acc) m_lfsr <= f_step(m_lfsr);
      if (!chan_en) m_sel <= mask_sel;
    end
  end

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at t=%0t", req, act, exp, $time);
    end
  endtask

  // output comparison every cycle, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst) begin
      if (cycles > 2) begin
        check("R1", dout, 12'h000);
        check("R1", {11'd0, dout_vld}, 12'h000);
      end
    end else begin
      check(tag, dout, m_out);
      check(tag, {11'd0, dout_vld}, {11'd0, m_vld});
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      trig = 1'b0;
    end
  endtask

  task automatic fire(input logic [11:0] b);
    @(negedge clk);
    base = b; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic set_sel(input logic [3:0] n);
    @(negedge clk);
    chan_en = 1'b0; mask_sel = n;
    @(negedge clk);
    chan_en = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd2024));
    idle(4);
    @(negedge clk);
    rst = 1'b0;
    // R1: seed visible with full mask
    tag = "R1";
    set_sel(4'd15);
    trig_en = 1'b1; wave_mode = 2'b01;
    fire(12'h000);
    idle(3);
    check("R1", dout, 12'h0AA);
    // R5: every selector over a freshly reloaded seed
    tag = "R5";
    for (int n = 0; n < 16; n++) begin
      set_sel(4'(n));
      @(negedge clk); wave_mode = 2'b00;
      @(negedge clk); wave_mode = 2'b01;
      fire(12'h100);
      idle(3);
      check("R5", dout, 12'h100 + (12'h0AA & f_mask(4'(n))));
    end
    // R6: saturation near full scale
    tag = "R6";
    set_sel(4'd15);
    fire(12'hFFF); idle(3);
    check("R6", dout, 12'hFFF);
    fire(12'hF80); idle(3);
    fire(12'h000); idle(3);
    // R2: rejected triggers
    tag = "R2";
    @(negedge clk); trig_en = 1'b0;
    fire(12'h123); idle(3);
    @(negedge clk); trig_en = 1'b1; wave_mode = 2'b10;
    fire(12'h456); idle(3);
    @(negedge clk); wave_mode = 2'b11;
    fire(12'h789); idle(3);
    @(negedge clk); wave_mode = 2'b01;
    fire(12'h000); idle(3);
    // R7: reload while a trigger is present
    tag = "R7";
    @(negedge clk); wave_mode = 2'b00; trig = 1'b1;
    @(negedge clk); wave_mode = 2'b01; trig = 1'b0;
    fire(12'h000); idle(3);
    check("R7", dout, 12'h0AA);
    // R8: selector changes ignored while enabled
    tag = "R8";
    set_sel(4'd2);
    @(negedge clk); mask_sel = 4'd15;
    fire(12'h000); idle(3);
    fire(12'h040); idle(3);
    // R9 / R4: back-to-back triggers
    tag = "R9";
    set_sel(4'd11);
    @(negedge clk); trig = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); base = 12'($urandom);
    end
    trig = 1'b0;
    idle(4);
    // R4 / R3: constrained random
    tag = "R4";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      trig    = ($urandom % 3) == 0;
      trig_en = ($urandom % 8) != 0;
      wave_mode = (($urandom % 40) == 0) ? 2'($urandom) : 2'b01;
      if (($urandom % 16) == 0) chan_en = ~chan_en;
      mask_sel = 4'($urandom);
      base = (($urandom % 4) == 0) ? (12'hF00 | 12'($urandom % 256)) : 12'($urandom);
      if (i == 2000) tag = "R3";
    end
    trig = 1'b0;
    idle(5);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule